// File: doc/BRIEF.md
# Byte-Serial Register Write Deserializer

This block takes register-write commands that arrive one byte per clock on an 8-bit bus. A start strobe marks the first byte of each command. A command is six bytes long. The first two bytes form a 16-bit address, low byte first. The last four bytes form a 32-bit data word, least significant byte first.

The block compares the assembled address with a base value under a mask. Only the address bits selected by the mask take part in the comparison. When they match, the block issues a one-cycle write pulse and a 5-bit local register address. The pulse and the local address appear a parameterized number of cycles (three by default) before the data word is complete. Downstream logic can use this lead to decode the target register and set up its own pipeline before the data arrives. The data word is loaded in a single step when the last byte lands, and it is held until the next complete command.

All logic runs on one clock. Reset is synchronous and active low.

Top module: `cmd_byte_deser`

## Requirements
- R1: Bytes are taken in this order: address bits 7:0, address bits 15:8, then data bits 7:0, 15:8, 23:16 and 31:24. Take the strobe cycle as cycle 0. The data output shows the new 32-bit word from cycle 6 on.
- R2: A command is accepted when (address AND 0x03E0) equals (0x0160 AND 0x03E0). Address bits outside the mask play no part in the comparison.
- R3: For an accepted command, the write pulse is high for exactly one cycle, in cycle 3. That is three cycles before the data becomes valid. The pulse is low in every other cycle.
- R4: The local address output equals address bits 4:0 of the accepted command. It updates in the same cycle as the write pulse and holds its value until the next accepted command.
- R5: Between updates, the data output holds its value. It changes only after the sixth byte of a command has been captured.
- R6: A strobe that arrives before a command finishes abandons that command and starts a new one with the byte presented alongside it. An abandoned command never changes the data output. It produces a write pulse only if it reached cycle 3 before it was cut off.
- R7: A command whose address does not match produces no write pulse and leaves the local address unchanged. Its data word is still assembled and appears on the data output.
- R8: While reset is low, the write pulse, the local address and the data output are all cleared. A command that is in progress when reset is applied is dropped.
- R9: Bytes that arrive without a strobe while no command is in progress are ignored. They produce no write pulse and no change on any output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cmd_byte | input | 8 | Serial command byte |
| cmd_start | input | 1 | High with the first byte of each command |
| reg_addr | output | 5 | Local register address of the last accepted command |
| reg_we | output | 1 | One-cycle write pulse, issued early |
| reg_data | output | 32 | Assembled data word of the last complete command |

## Verification
The bench sweeps every value of the low eleven address bits. This sweep tells the 32-address window that matches apart from its neighbours, and it shows that bit 10 has no effect. A few addresses with high bits set show that only the masked bits count.

The commands in the sweep are mixed: some run back to back and some are separated by idle gaps. This checks that the early pulse and the late data change stay in step with each command and do not leak into the next one.

The bench also cuts commands off after one to five bytes. These cases separate aborts that come before the early pulse from aborts that come after it. Stray bytes with no strobe, and a reset applied in the middle of a command, confirm that neither one can produce a write.

// File: rtl/cmdser_pkg.sv
// Shared definitions for the byte-serial command deserializer.
// Assumes a byte-wide transport lane.
package cmdser_pkg;
    localparam int BYTE_W = 8;
    typedef logic [BYTE_W-1:0] lane_t;
endpackage

// File: rtl/cmdser_collect.sv
// Byte collector: tracks the byte position inside a command and stores the
// address lanes and data lanes. The data word is published in one step when
// the final byte arrives.
// Assumes the bytes of one command come on consecutive cycles, and that a
// start strobe always restarts collection.
module cmdser_collect
    import cmdser_pkg::*;
#(
    parameter int ADDR_BYTES = 2,
    parameter int DATA_BYTES = 4
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  lane_t                          in_byte,
    input  logic                           in_start,
    output logic [$clog2(ADDR_BYTES+DATA_BYTES+1)-1:0] pos,
    output logic                           busy,
    output logic [ADDR_BYTES*BYTE_W-1:0]   cmd_addr,
    output logic [DATA_BYTES*BYTE_W-1:0]   cmd_data
);
    localparam int CMD_LEN = ADDR_BYTES + DATA_BYTES;
    localparam int CW      = $clog2(CMD_LEN + 1);
    localparam int SHW     = (DATA_BYTES - 1) * BYTE_W;

    logic [CMD_LEN-1:0] take;
    logic [SHW-1:0]     shadow;

    // One select per byte position; the strobe always means position 0
    for (genvar p = 0; p < CMD_LEN; p++) begin : g_take
        assign take[p] = in_start ? (p == 0) : (busy && pos == CW'(p));
    end

    // Position counter: restart on a strobe, go idle after the last byte
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos  <= '0;
            busy <= 1'b0;
        end else if (in_start) begin
            pos  <= CW'(1);
            busy <= 1'b1;
        end else if (busy) begin
            if (pos == CW'(CMD_LEN - 1)) begin
                pos  <= '0;
                busy <= 1'b0;
            end else begin
                pos <= pos + 1'b1;
            end
        end
    end

    // Address lanes, low byte first
    for (genvar i = 0; i < ADDR_BYTES; i++) begin : g_alane
        lane_t q;
        // Capture this address lane at its position
        always_ff @(posedge clk) begin
            if (!rst_n)       q <= '0;
            else if (take[i]) q <= in_byte;
        end
        assign cmd_addr[i*BYTE_W +: BYTE_W] = q;
    end

    // Data lanes except the last one are held in a shadow register
    for (genvar j = 0; j < DATA_BYTES - 1; j++) begin : g_dlane
        lane_t q;
        // Capture this data lane at its position
        always_ff @(posedge clk) begin
            if (!rst_n)                    q <= '0;
            else if (take[ADDR_BYTES + j]) q <= in_byte;
        end
        assign shadow[j*BYTE_W +: BYTE_W] = q;
    end

    // Publish the whole word together with the final byte
    always_ff @(posedge clk) begin
        if (!rst_n)                 cmd_data <= '0;
        else if (take[CMD_LEN-1])   cmd_data <= {in_byte, shadow};
    end

    p_pos_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
        pos <= CW'(CMD_LEN - 1));
    p_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
        in_start |=> (busy && pos == CW'(1)));
    p_data_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cmd_data) |-> (!busy && pos == '0));
endmodule

// File: rtl/cmdser_decode.sv
// Address decoder: at the chosen byte position it compares the masked
// address with the base, and it registers a one-cycle write pulse together
// with the local address.
// Assumes the address is complete by the time the pulse position is reached.
module cmdser_decode #(
    parameter int          AW       = 16,
    parameter int          LOC_AW   = 5,
    parameter int          CW       = 3,
    parameter int          FIRE_POS = 2,
    parameter logic [31:0] BASE     = 32'h0000_0160,
    parameter logic [31:0] MASK     = 32'h0000_03E0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              busy,
    input  logic              in_start,
    input  logic [CW-1:0]     pos,
    input  logic [AW-1:0]     cmd_addr,
    output logic              reg_we,
    output logic [LOC_AW-1:0] reg_addr
);
    localparam logic [AW-1:0] MASK_W = MASK[AW-1:0];
    localparam logic [AW-1:0] BASE_W = BASE[AW-1:0] & MASK[AW-1:0];

    logic fire, hit;
    assign fire = busy && !in_start && (pos == CW'(FIRE_POS));
    assign hit  = (cmd_addr & MASK_W) == BASE_W;

    // Registered pulse and local address on a matching command
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reg_we   <= 1'b0;
            reg_addr <= '0;
        end else begin
            reg_we <= fire && hit;
            if (fire && hit) reg_addr <= cmd_addr[LOC_AW-1:0];
        end
    end

    p_we_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |=> !reg_we);
    p_we_match_r7: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |-> (($past(cmd_addr) & MASK_W) == BASE_W));
endmodule

// File: rtl/cmd_byte_deser.sv
// Top level of the byte-serial register write deserializer. It joins the
// byte collector and the address decoder. The write pulse leads the
// completed data word by EARLY cycles.
// Assumes 0 <= EARLY <= DATA_BYTES-1, so the address is complete before the
// pulse, and assumes DATA_BYTES >= 2.
module cmd_byte_deser
    import cmdser_pkg::*;
#(
    parameter int          ADDR_BYTES = 2,
    parameter int          DATA_BYTES = 4,
    parameter int          LOC_AW     = 5,
    parameter int          EARLY      = 3,
    parameter logic [31:0] BASE_ADDR  = 32'h0000_0160,
    parameter logic [31:0] ADDR_MASK  = 32'h0000_03E0
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [BYTE_W-1:0]            cmd_byte,
    input  logic                         cmd_start,
    output logic [LOC_AW-1:0]            reg_addr,
    output logic                         reg_we,
    output logic [DATA_BYTES*BYTE_W-1:0] reg_data
);
    localparam int CMD_LEN  = ADDR_BYTES + DATA_BYTES;
    localparam int CW       = $clog2(CMD_LEN + 1);
    localparam int AW       = ADDR_BYTES * BYTE_W;
    localparam int FIRE_POS = CMD_LEN - EARLY - 1;

    logic [CW-1:0] pos;
    logic          busy;
    logic [AW-1:0] cmd_addr;

    cmdser_collect #(
        .ADDR_BYTES (ADDR_BYTES),
        .DATA_BYTES (DATA_BYTES)
    ) i_collect (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_byte  (cmd_byte),
        .in_start (cmd_start),
        .pos      (pos),
        .busy     (busy),
        .cmd_addr (cmd_addr),
        .cmd_data (reg_data)
    );

    cmdser_decode #(
        .AW       (AW),
        .LOC_AW   (LOC_AW),
        .CW       (CW),
        .FIRE_POS (FIRE_POS),
        .BASE     (BASE_ADDR),
        .MASK     (ADDR_MASK)
    ) i_decode (
        .clk      (clk),
        .rst_n    (rst_n),
        .busy     (busy),
        .in_start (cmd_start),
        .pos      (pos),
        .cmd_addr (cmd_addr),
        .reg_we   (reg_we),
        .reg_addr (reg_addr)
    );

    p_we_timing_r3: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |-> ($past(busy) && $past(pos) == CW'(FIRE_POS)));
    p_addr_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_we |-> $stable(reg_addr));
endmodule

// File: tb/test_cmd_byte_deser.sv
module test_cmd_byte_deser;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [7:0]  cmd_byte;
    logic        cmd_start;
    logic [4:0]  reg_addr;
    logic        reg_we;
    logic [31:0] reg_data;

    always #5 clk = ~clk;

    cmd_byte_deser i_cmd_byte_deser (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_byte  (cmd_byte),
        .cmd_start (cmd_start),
        .reg_addr  (reg_addr),
        .reg_we    (reg_we),
        .reg_data  (reg_data)
    );

    int n_checks = 0;
    int n_errors = 0;

    // Reference model: values expected at the next sample, plus countdowns
    // to pending events (-1 means nothing pending)
    logic [4:0]  exp_addr = '0;
    logic [31:0] exp_data = '0;
    logic [4:0]  pend_addr = '0;
    logic [31:0] pend_data = '0;
    int          we_cd = -1;
    int          dt_cd = -1;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic hit_of(input logic [15:0] a);
        return (a & 16'h03E0) == 16'h0160;
    endfunction

    // Compare the outputs with the model at a falling edge, then step the
    // countdowns
    task automatic sample(input string ctx);
        logic we_now;
        logic dt_now;
        we_now = (we_cd == 0);
        dt_now = (dt_cd == 0);
        if (we_now) exp_addr = pend_addr;
        if (dt_now) exp_data = pend_data;
        chk(we_now ? "R3" : ctx, {31'b0, reg_we}, {31'b0, we_now});
        chk(we_now ? "R4" : ctx, {27'b0, reg_addr}, {27'b0, exp_addr});
        chk(dt_now ? "R1" : "R5", reg_data, exp_data);
        if (we_cd >= 0) we_cd--;
        if (dt_cd >= 0) dt_cd--;
    endtask

    // Send the first nbytes of a command (6 means a complete command)
    task automatic send(input logic [15:0] a, input logic [31:0] d, input int nbytes, input string ctx);
        logic [7:0] b [6];
        b[0] = a[7:0];   b[1] = a[15:8];
        b[2] = d[7:0];   b[3] = d[15:8];
        b[4] = d[23:16]; b[5] = d[31:24];
        for (int i = 0; i < nbytes; i++) begin
            @(negedge clk);
            sample(ctx);
            if (i == 0) begin
                // R2/R7: a pulse is due three samples later only on a match
                we_cd     = hit_of(a) ? 2 : -1;
                pend_addr = a[4:0];
                dt_cd     = 5;
                pend_data = d;
            end
            cmd_start = (i == 0);
            cmd_byte  = b[i];
        end
    endtask

    // Idle cycles, with stray bytes and no strobe
    task automatic idle(input int n, input string ctx);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            sample(ctx);
            cmd_start = 1'b0;
            cmd_byte  = 8'(8'hA5 ^ (i * 37));
        end
    endtask

    task automatic finish_run;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        rst_n = 1'b0; cmd_start = 1'b0; cmd_byte = 8'h00;
        repeat (3) @(negedge clk);
        // R8: reset state
        chk("R8", {31'b0, reg_we}, 32'd0);
        chk("R8", {27'b0, reg_addr}, 32'd0);
        chk("R8", reg_data, 32'd0);
        rst_n = 1'b1;

        // R9: stray bytes while idle
        idle(10, "R9");

        // R2/R7: sweep the low eleven address bits, some back to back
        for (int a = 0; a < 2048; a++) begin
            send(16'(a), 32'(a) * 32'h9E37_79B1 ^ 32'h5A5A_0000, 6,
                 hit_of(16'(a)) ? "R2" : "R7");
            if (a % 3 == 0) idle(1, "R3");
        end

        // R2: high bits outside the mask
        send(16'hFD7F, 32'hDEAD_BEEF, 6, "R2");
        send(16'h8160, 32'h0123_4567, 6, "R2");
        send(16'h0360, 32'h89AB_CDEF, 6, "R7");
        idle(3, "R7");

        // R6: abort after k bytes, followed at once by a full command
        for (int k = 1; k < 6; k++) begin
            send(16'(16'h0160 + k), 32'hF0F0_0000 + 32'(k), k, "R6");
            send(16'h0171, 32'h1111_0000 + 32'(k), 6, "R6");
        end
        send(16'h0040, 32'h7777_7777, 3, "R6");
        send(16'h0165, 32'h2468_ACE0, 6, "R6");
        idle(8, "R6");

        // R8: reset in the middle of a matching command
        send(16'h016A, 32'hCAFE_F00D, 2, "R8");
        @(negedge clk);
        rst_n = 1'b0; cmd_start = 1'b0;
        repeat (3) @(negedge clk);
        chk("R8", {31'b0, reg_we}, 32'd0);
        chk("R8", {27'b0, reg_addr}, 32'd0);
        chk("R8", reg_data, 32'd0);
        rst_n = 1'b1;
        exp_addr = '0; exp_data = '0; we_cd = -1; dt_cd = -1;
        idle(8, "R8");
        send(16'h017E, 32'h5555_AAAA, 6, "R1");
        idle(8, "R1");
        finish_run();
    end
endmodule